// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits in a UART receive path, after the deserializer and ahead of the receive FIFO. Each received character arrives with a one-cycle valid strobe. The block compares the character against four programmable flow-control characters, split into two pairs: pair 1 (resume-1 and pause-1) and pair 2 (resume-2 and pause-2). The pause-2 character also serves as the special-character pattern.

The block decides in the same cycle whether the character goes into the FIFO. It raises two sticky interrupt flags, one for a special character and one for a pause request. It also keeps a pause state that the transmitter uses to stop sending.

Software chooses which pair is active with a two-bit flow-control mode:
- `2'b10` selects pair 1.
- `2'b01` selects pair 2.
- `2'b00` and `2'b11` turn flow-control recognition off.

A separate enable turns on special-character detection. The mode decides whether a character that matches the special pattern is stored, or swallowed as a flow-control character.

Top module: `rx_spchar_detect`

## Requirements
- R1: After reset, `spc_flag`, `xoff_flag` and `tx_halt` are 0.
- R2: While `det_en` is 0, no received character sets `spc_flag`.
- R3: While `det_en` is 1, a valid character equal bit for bit to `xoff2` (bit 0 against the character's LSB) sets `spc_flag` at the next clock edge. When this mode does not swallow it, the character is still written (`fifo_wr`=1).
- R4: With `fc_mode`=2'b10, a character equal to `xon1` or `xoff1` is swallow (`fifo_wr`=0). A character equal to `xoff2` and to neither of those is stored, and it sets `spc_flag` when detection is enabled.
- R5: With `fc_mode`=2'b01, a character equal to `xoff2` is swallowed. It sets `xoff_flag`, and when `det_en`=1 it also sets `spc_flag` at the same edge. A character equal to `xon2` is also swallowed.
- R6: With `fc_mode` 2'b00 or 2'b11, no character is swallowed, and `xoff_flag` and `tx_halt` never change.
- R7: A valid pause character of the active pair sets `tx_halt` and `xoff_flag` at the next edge. A valid resume character of the active pair clears `tx_halt`. When the resume and pause characters are equal, pause wins.
- R8: A one-cycle `flag_clr` clears both flags at the next edge. A flag being set in the same cycle stays 1.
- R9: `fifo_wr` is combinational. It equals `rx_valid` and not swallowed, and it is never 1 without `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` valid |
| det_en | input | 1 | Special-character detection enable |
| fc_mode | input | 2 | Flow-control pair select: 01 pair 2, 10 pair 1, 00/11 off |
| xon1 | input | 8 | Resume character, pair 1 |
| xoff1 | input | 8 | Pause character, pair 1 |
| xon2 | input | 8 | Resume character, pair 2 |
| xoff2 | input | 8 | Pause character, pair 2; also the special pattern |
| flag_clr | input | 1 | One-cycle clear for both interrupt flags |
| fifo_wr | output | 1 | Write enable to the receive FIFO |
| spc_flag | output | 1 | Sticky special-character interrupt flag |
| xoff_flag | output | 1 | Sticky pause-received interrupt flag |
| tx_halt | output | 1 | Pause state for the transmitter |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is flag setting and flag clearing. The bench drives `flag_clr` on a fixed stride through a sweep of every character value under every mode and enable setting. Some clears therefore land on cycles that also carry a hit. The result is judged against a flag model that gives the set priority.

The second pair is the two interrupts raised by one character. A pause-2 character in mode 01 must set both flags at one edge while `fifo_wr` stays low. The bench checks all three outputs in that cycle and at the edge after it.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;
  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_PAIR2 = 2'b01,
    FC_PAIR1 = 2'b10,
    FC_NONE2 = 2'b11
  } fc_mode_e;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_SPC  = 0;
  localparam int FLAG_XOFF = 1;

  function automatic logic fc_enabled(input logic [1:0] mode);
    return (mode == FC_PAIR1) || (mode == FC_PAIR2);
  endfunction

  function automatic logic fc_uses_pair2(input logic [1:0] mode);
    return mode == FC_PAIR2;
  endfunction
endpackage

// File: rtl/rxsc_match.sv
module rxsc_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_data,
  input  logic [1:0]        fc_mode,
  input  logic              det_en,
  input  logic [DATA_W-1:0] xon1,
  input  logic [DATA_W-1:0] xoff1,
  input  logic [DATA_W-1:0] xon2,
  input  logic [DATA_W-1:0] xoff2,
  output logic              hit_xon,
  output logic              hit_xoff,
  output logic              hit_spc
);
  import rxsc_pkg::*;

  logic [DATA_W-1:0] act_xon;
  logic [DATA_W-1:0] act_xoff;
  logic              fc_on;

  always_comb begin
    fc_on    = fc_enabled(fc_mode);
    act_xon  = fc_uses_pair2(fc_mode) ? xon2  : xon1;
    act_xoff = fc_uses_pair2(fc_mode) ? xoff2 : xoff1;
    hit_xoff = fc_on && (rx_data == act_xoff);
    hit_xon  = fc_on && (rx_data == act_xon);
    hit_spc  = det_en && (rx_data == xoff2);
  end
endmodule

// File: rtl/rxsc_flag.sv
module rxsc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R8
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
endmodule

// File: rtl/rxsc_flowstate.sv
module rxsc_flowstate (
  input  logic clk,
  input  logic rst_n,
  input  logic xon_ev,
  input  logic xoff_ev,
  output logic halt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt <= 1'b0;
    else if (xoff_ev) halt <= 1'b1;
    else if (xon_ev)  halt <= 1'b0;
  end

  // R7
  pause_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_ev |=> halt);
  // R7
  resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xon_ev && !xoff_ev) |=> !halt);
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xon_ev && !xoff_ev) |=> $stable(halt));
endmodule

// File: rtl/rx_spchar_detect.sv
module rx_spchar_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              det_en,
  input  logic [1:0]        fc_mode,
  input  logic [DATA_W-1:0] xon1,
  input  logic [DATA_W-1:0] xoff1,
  input  logic [DATA_W-1:0] xon2,
  input  logic [DATA_W-1:0] xoff2,
  input  logic              flag_clr,
  output logic              fifo_wr,
  output logic              spc_flag,
  output logic              xoff_flag,
  output logic              tx_halt
);
  import rxsc_pkg::*;

  logic hit_xon, hit_xoff, hit_spc;
  logic ev_xon, ev_xoff, ev_spc, ev_swallow;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  rxsc_match #(.DATA_W(DATA_W)) u_match (
    .rx_data (rx_data),
    .fc_mode (fc_mode),
    .det_en  (det_en),
    .xon1    (xon1),
    .xoff1   (xoff1),
    .xon2    (xon2),
    .xoff2   (xoff2),
    .hit_xon (hit_xon),
    .hit_xoff(hit_xoff),
    .hit_spc (hit_spc)
  );

  assign ev_xon     = rx_valid && hit_xon;
  assign ev_xoff    = rx_valid && hit_xoff;
  assign ev_spc     = rx_valid && hit_spc;
  assign ev_swallow = ev_xon || ev_xoff;
  assign fifo_wr    = rx_valid && !ev_swallow;

  assign flag_set[FLAG_SPC]  = ev_spc;
  assign flag_set[FLAG_XOFF] = ev_xoff;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    rxsc_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set[g]),
      .clr  (flag_clr),
      .q    (flag_q[g])
    );
  end

  assign spc_flag  = flag_q[FLAG_SPC];
  assign xoff_flag = flag_q[FLAG_XOFF];

  rxsc_flowstate u_flow (
    .clk    (clk),
    .rst_n  (rst_n),
    .xon_ev (ev_xon),
    .xoff_ev(ev_xoff),
    .halt   (tx_halt)
  );

  // R9
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !fifo_wr);
  // R5
  pair2_pause_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_mode == 2'b01 && rx_data == xoff2) |-> !fifo_wr);
  // R5
  dual_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && det_en && fc_mode == 2'b01 && rx_data == xoff2) |=> (spc_flag && xoff_flag));
  // R6
  fc_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (fc_mode == 2'b00 || fc_mode == 2'b11)) |-> fifo_wr);
  // R2
  det_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !spc_flag) |=> !spc_flag);
  // R3
  spc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && det_en && rx_data == xoff2) |=> spc_flag);
endmodule

// File: tb/rx_spchar_detect_test.sv
module rx_spchar_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0;
  logic       det_en = 1'b0;
  logic [1:0] fc_mode = 2'b00;
  logic [7:0] xon1 = 8'h11, xoff1 = 8'h13, xon2 = 8'h51, xoff2 = 8'h53;
  logic       flag_clr = 1'b0;
  logic       fifo_wr, spc_flag, xoff_flag, tx_halt;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic m_spc = 0, m_xoff = 0, m_halt = 0;

  rx_spchar_detect uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .det_en(det_en), .fc_mode(fc_mode), .xon1(xon1), .xoff1(xoff1),
    .xon2(xon2), .xoff2(xoff2), .flag_clr(flag_clr), .fifo_wr(fifo_wr),
    .spc_flag(spc_flag), .xoff_flag(xoff_flag), .tx_halt(tx_halt)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [7:0] d, input logic clr);
    logic p, r, pause, resume, spc, wr;
    @(negedge clk);
    rx_valid = v; rx_data = d; flag_clr = clr;
    p = (fc_mode == 2'b01) ? (d == xoff2) : (fc_mode == 2'b10) ? (d == xoff1) : 1'b0;
    r = (fc_mode == 2'b01) ? (d == xon2)  : (fc_mode == 2'b10) ? (d == xon1)  : 1'b0;
    pause = v & p; resume = v & r;
    spc = v & det_en & (d == xoff2);
    wr = v & ~(p | r);
    #1;
    check("R9 fifo_wr", fifo_wr, wr);
    m_spc  = spc   ? 1'b1 : (clr ? 1'b0 : m_spc);
    m_xoff = pause ? 1'b1 : (clr ? 1'b0 : m_xoff);
    m_halt = pause ? 1'b1 : (resume ? 1'b0 : m_halt);
    @(posedge clk); #1;
    check("R3/R8 spc_flag", spc_flag, m_spc);
    check("R7/R8 xoff_flag", xoff_flag, m_xoff);
    check("R7 tx_halt", tx_halt, m_halt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 spc_flag", spc_flag, 1'b0);
    check("R1 xoff_flag", xoff_flag, 1'b0);
    check("R1 tx_halt", tx_halt, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R6 sweep: every value, every mode, both enables; stride clears
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        det_en = e[0]; fc_mode = m[1:0];
        for (int d = 0; d < 256; d++)
          apply(1'b1, d[7:0], (d % 7) == 3);
        apply(1'b0, 8'h53, 1'b1);
      end
    end

    // R5 dual interrupt from one pause-2 character, swallowed
    @(negedge clk); det_en = 1'b1; fc_mode = 2'b01;
    apply(1'b0, 8'h00, 1'b1);
    apply(1'b1, 8'h53, 1'b0);
    check("R5 both flags", spc_flag & xoff_flag, 1'b1);

    // R8 clear with simultaneous hit keeps flag set
    apply(1'b1, 8'h53, 1'b1);
    check("R8 set beats clear", spc_flag, 1'b1);
    apply(1'b0, 8'h00, 1'b1);
    check("R8 cleared", spc_flag | xoff_flag, 1'b0);

    // R7 resume-2 clears halt; equal resume/pause means pause wins
    apply(1'b1, 8'h51, 1'b0);
    check("R7 resume clears", tx_halt, 1'b0);
    @(negedge clk); xon2 = 8'h53;
    apply(1'b1, 8'h53, 1'b0);
    check("R7 pause wins", tx_halt, 1'b1);
    @(negedge clk); xon2 = 8'h51;

    // R2 detection disabled: special pattern under mode 00 sets nothing
    @(negedge clk); det_en = 1'b0; fc_mode = 2'b00;
    apply(1'b0, 8'h00, 1'b1);
    apply(1'b1, 8'h53, 1'b0);
    check("R2 no spc", spc_flag, 1'b0);

    // R9 idle strobe never writes
    apply(1'b0, 8'h41, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule